// File: doc/BRIEF.md
# Dual-Mode Serial Transmitter

This block is the transmit half of a serial port. It has two modes. In asynchronous mode it sends framed characters on one line and uses a baud-tick input to time each bit. In synchronous mode it shifts bits out alongside a shift clock. In that mode it either produces the clock itself from the baud ticks (master) or follows a clock supplied from outside (slave). One 8-bit control register holds all the settings: mode, clock source, frame length (8 or 9 data bits), transmit enable, bit speed and the value of the ninth bit. The same register reports whether the shifter is empty.

Software writes a byte into a one-byte holding register. When transmission is enabled and the shifter is free, the byte moves into the shifter on the next clock. While one character is being sent, software can write the next byte into the holding register. That byte follows directly after the current character. Synchronous mode is half duplex, so when either receive-enable input is active in that mode, transmission is blocked. The pins are driven only while the global port-enable input is high.

Top module: `usart_tx_unit`

## Requirements
- R1: After reset the control register reads 8'h02, `txd_o` is high and `sclk_o` is low.
- R2: Control register layout: bit 7 selects synchronous mode, bit 6 selects master clocking, bit 5 selects 9-bit frames, bit 4 enables transmission, bit 3 selects the fast bit time, and bit 0 holds the ninth bit value. All of these read back as written. Bit 2 always reads 0. Bit 1 is read-only and reads 1 while the shifter is empty.
- R3: A holding-register write made while the shifter is empty and transmission is allowed loads the shifter on the next clock edge. From that edge, status bit 1 reads 0. It returns to 1 once the last bit has been shifted out.
- R4: An asynchronous frame is sent on `txd_o` in this order: a low start bit, eight data bits LSB first, the ninth bit if enabled, and a high stop bit. Each bit lasts 16 baud ticks when bit 3 is 0 and 4 ticks when bit 3 is 1. The line idles high.
- R5: In synchronous mode, bit 3 has no effect. In master mode, each baud tick toggles the shift clock, so every bit takes exactly two ticks.
- R6: In synchronous master mode, `sclk_o` idles low. Bits are sent LSB first with no start or stop bit. `txd_o` changes only on a falling edge of `sclk_o`, so each bit is valid at the rising edge that follows it.
- R7: In synchronous slave mode, the block does not drive `sclk_oe`. The shifter advances to the next bit after each falling edge of `ext_sclk`, which first passes through a two-stage synchronizer.
- R8: When bit 5 is set, the ninth bit sent is the value of control bit 0 at the moment the shifter loads. This applies in both modes.
- R9: In synchronous mode, a high `rx_once_en` or `rx_cont_en` stops any frame in progress and prevents loading. It also turns off `txd_oe`. In asynchronous mode these inputs have no effect.
- R10: While bit 4 is 0, nothing loads and the shifter stays empty. A byte already in the holding register is kept and is sent once bit 4 is set.
- R11: While `port_en` is low, `txd_oe` and `sclk_oe` are both 0.
- R12: A holding-register write made during a frame is loaded one cycle after that frame ends, and it is then sent as the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value, including the shifter-empty status |
| hold_wr | input | 1 | Holding register write strobe |
| hold_wdata | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | One-cycle pulse from the baud generator |
| port_en | input | 1 | Global serial-port enable for the pins |
| rx_once_en | input | 1 | Single-receive enable from the receiver |
| rx_cont_en | input | 1 | Continuous-receive enable from the receiver |
| ext_sclk | input | 1 | External shift clock used in slave mode |
| txd_o | output | 1 | Serial data out |
| txd_oe | output | 1 | Serial data output enable |
| sclk_o | output | 1 | Shift clock out in master mode |
| sclk_oe | output | 1 | Shift clock output enable |

## Verification
The bench generates baud ticks at random densities. In asynchronous mode it counts each tick as it is consumed, which catches a design that miscounts the per-bit tick count. The same count also catches one that starts counting before the load edge, or one that drops or duplicates the stop bit or the ninth bit.

In master mode, the bench samples data on each rising clock edge and counts the ticks used. A design that let the fast-speed bit change the clock, or that moved data on the rising edge, would corrupt the captured word.

Directed cases cover three situations:
- A receive enable asserted mid-frame. A design that ignored the override would keep the status busy.
- A byte written while transmission is disabled. A design that dropped that byte would never send it.
- A byte written during a frame. A design that loaded it early would corrupt the stop bit.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;
  localparam int unsigned CTRL_W  = 8;
  localparam int unsigned B_SYNC  = 7;
  localparam int unsigned B_MSTR  = 6;
  localparam int unsigned B_NINE  = 5;
  localparam int unsigned B_TXEN  = 4;
  localparam int unsigned B_FAST  = 3;
  localparam int unsigned B_RSVD  = 2;
  localparam int unsigned B_EMPTY = 1;
  localparam int unsigned B_XBIT  = 0;

  typedef struct packed {
    logic sync;
    logic master;
    logic nine;
    logic txen;
    logic fast;
    logic xbit;
  } tx_cfg_t;
endpackage

// File: rtl/usart_tx_ctrl.sv
module usart_tx_ctrl
  import usart_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              sr_empty,
  output tx_cfg_t           cfg,
  output logic [CTRL_W-1:0] rd_data
);
  tx_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.sync   = wr_data[B_SYNC];
      cfg_d.master = wr_data[B_MSTR];
      cfg_d.nine   = wr_data[B_NINE];
      cfg_d.txen   = wr_data[B_TXEN];
      cfg_d.fast   = wr_data[B_FAST];
      cfg_d.xbit   = wr_data[B_XBIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_SYNC]  = cfg_q.sync;
    rd_data[B_MSTR]  = cfg_q.master;
    rd_data[B_NINE]  = cfg_q.nine;
    rd_data[B_TXEN]  = cfg_q.txen;
    rd_data[B_FAST]  = cfg_q.fast;
    rd_data[B_RSVD]  = 1'b0;
    rd_data[B_EMPTY] = sr_empty;
    rd_data[B_XBIT]  = cfg_q.xbit;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/usart_tx_pace.sv
module usart_tx_pace #(
  parameter int unsigned SLOW_TICKS  = 16,
  parameter int unsigned FAST_TICKS  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sync_mode,
  input  logic master_mode,
  input  logic fast_mode,
  input  logic baud_tick,
  input  logic ext_clk,
  output logic step,
  output logic sclk
);
  localparam int unsigned MAX_T = (SLOW_TICKS > FAST_TICKS) ? SLOW_TICKS : FAST_TICKS;
  localparam int unsigned CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0]     cnt_q, cnt_d, lim;
  logic                 sclk_q, sclk_d;
  logic [SYNC_STAGES:0] xs_q;
  logic                 ext_fall;

  assign lim = fast_mode ? CNT_W'(FAST_TICKS - 1) : CNT_W'(SLOW_TICKS - 1);

  // synchronizer stages plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xs_q <= '0;
    else begin
      xs_q[0] <= ext_clk;
      for (int i = 1; i <= SYNC_STAGES; i++) xs_q[i] <= xs_q[i-1];
    end
  end

  assign ext_fall = xs_q[SYNC_STAGES] & ~xs_q[SYNC_STAGES-1];

  always_comb begin
    step   = 1'b0;
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (!sync_mode) begin
      if (baud_tick) begin
        if (cnt_q >= lim) begin
          cnt_d = '0;
          step  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end else if (master_mode) begin
      if (baud_tick) begin
        sclk_d = ~sclk_q;
        step   = sclk_q;
      end
    end else begin
      step = ext_fall;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/usart_tx_shift.sv
module usart_tx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              pend,
  input  logic [DATA_W-1:0] pend_data,
  input  logic              sync_mode,
  input  logic              nine_mode,
  input  logic              xbit,
  input  logic              step,
  output logic              busy,
  output logic              line,
  output logic              take
);
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   left_q, left_d;
  logic               busy_q, busy_d;

  assign take = go & pend & ~busy_q;

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    if (!go) begin
      busy_d = 1'b0;
      sh_d   = '1;
      left_d = '0;
    end else if (take) begin
      busy_d = 1'b1;
      if (sync_mode) begin
        sh_d   = {2'b11, xbit, pend_data};
        left_d = nine_mode ? CNT_W'(DATA_W + 1) : CNT_W'(DATA_W);
      end else begin
        sh_d   = {1'b1, (nine_mode ? xbit : 1'b1), pend_data, 1'b0};
        left_d = nine_mode ? CNT_W'(DATA_W + 3) : CNT_W'(DATA_W + 2);
      end
    end else if (busy_q && step) begin
      sh_d   = {1'b1, sh_q[FRAME_W-1:1]};
      left_d = left_q - CNT_W'(1);
      if (left_q == CNT_W'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign line = sh_q[0];

  // R4: the frame only moves when the pacing logic grants a step
  p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && go && !step) |=> $stable(sh_q));
endmodule

// File: rtl/usart_tx_unit.sv
module usart_tx_unit
  import usart_tx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SLOW_TICKS  = 16,
  parameter int unsigned FAST_TICKS  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTRL_W-1:0] ctl_wdata,
  output logic [CTRL_W-1:0] ctl_rdata,
  input  logic              hold_wr,
  input  logic [DATA_W-1:0] hold_wdata,
  input  logic              baud_tick,
  input  logic              port_en,
  input  logic              rx_once_en,
  input  logic              rx_cont_en,
  input  logic              ext_sclk,
  output logic              txd_o,
  output logic              txd_oe,
  output logic              sclk_o,
  output logic              sclk_oe
);
  logic [1:0]        rst_sync_q;
  logic              rst_i;
  tx_cfg_t           cfg;
  logic              go, busy, line, take, step, sclk;
  logic [DATA_W-1:0] hold_q;
  logic              hold_full_q, hold_full_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  assign go = cfg.txen & ~(cfg.sync & (rx_once_en | rx_cont_en));

  usart_tx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_i),
    .wr_en    (ctl_wr),
    .wr_data  (ctl_wdata),
    .sr_empty (~busy),
    .cfg      (cfg),
    .rd_data  (ctl_rdata)
  );

  always_comb begin
    hold_full_d = hold_full_q;
    if (take)    hold_full_d = 1'b0;
    if (hold_wr) hold_full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
    end else begin
      hold_full_q <= hold_full_d;
      if (hold_wr) hold_q <= hold_wdata;
    end
  end

  usart_tx_pace #(
    .SLOW_TICKS  (SLOW_TICKS),
    .FAST_TICKS  (FAST_TICKS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_pace (
    .clk         (clk),
    .rst_n       (rst_i),
    .run         (busy & go),
    .sync_mode   (cfg.sync),
    .master_mode (cfg.master),
    .fast_mode   (cfg.fast),
    .baud_tick   (baud_tick),
    .ext_clk     (ext_sclk),
    .step        (step),
    .sclk        (sclk)
  );

  usart_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_i),
    .go        (go),
    .pend      (hold_full_q),
    .pend_data (hold_q),
    .sync_mode (cfg.sync),
    .nine_mode (cfg.nine),
    .xbit      (cfg.xbit),
    .step      (step),
    .busy      (busy),
    .line      (line),
    .take      (take)
  );

  assign txd_o   = line;
  assign txd_oe  = port_en & (~cfg.sync | go);
  assign sclk_o  = sclk;
  assign sclk_oe = port_en & cfg.sync & cfg.master & go;

  // R3: a pending byte with a free shifter is taken at the next edge
  p_load_next_r3: assert property (@(posedge clk) disable iff (!rst_i)
    (hold_full_q && go && !busy) |=> busy);

  // R6: the master clock rests low whenever no frame is in flight
  p_clk_rests_low_r6: assert property (@(posedge clk) disable iff (!rst_i)
    !busy |-> !sclk);

  // R6: in master mode the data line moves only with a falling clock
  p_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg.sync && cfg.master && busy && $past(busy) && !$stable(line)) |-> $fell(sclk));

  // R9: a receive enable in synchronous mode ends transmission
  p_rx_wins_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (cfg.sync && (rx_once_en || rx_cont_en)) |=> !busy);
endmodule

// File: tb/test_usart_tx_unit.sv
`timescale 1ns/1ps
module test_usart_tx_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr;
  logic [7:0] ctl_wdata, ctl_rdata;
  logic       hold_wr;
  logic [7:0] hold_wdata;
  logic       baud_tick, port_en, rx_once_en, rx_cont_en, ext_sclk;
  logic       txd_o, txd_oe, sclk_o, sclk_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  usart_tx_unit i_usart_tx_unit (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .hold_wr(hold_wr), .hold_wdata(hold_wdata),
    .baud_tick(baud_tick), .port_en(port_en), .rx_once_en(rx_once_en),
    .rx_cont_en(rx_cont_en), .ext_sclk(ext_sclk), .txd_o(txd_o),
    .txd_oe(txd_oe), .sclk_o(sclk_o), .sclk_oe(sclk_oe)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mk_ctl(input logic sy, input logic ms, input logic nn,
                                        input logic te, input logic fs, input logic xb);
    return {sy, ms, nn, te, fs, 1'b0, 1'b0, xb};
  endfunction

  function automatic logic [10:0] exp_frame(input logic sy, input logic nn, input logic xb,
                                            input logic [7:0] d);
    if (sy) return {2'b11, xb, d};
    return {1'b1, (nn ? xb : 1'b1), d, 1'b0};
  endfunction

  function automatic int exp_bits(input logic sy, input logic nn);
    if (sy) return nn ? 9 : 8;
    return nn ? 11 : 10;
  endfunction

  task automatic set_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic put_hold(input logic [7:0] d);
    @(negedge clk); hold_wr = 1'b1; hold_wdata = d;
    @(negedge clk); hold_wr = 1'b0;
  endtask

  // capture one asynchronous frame, counting consumed ticks
  task automatic run_async(input logic [7:0] d, input logic nn, input logic xb, input logic fs,
                           input int dens, input bit mid, input logic [7:0] mid_d, input string tag);
    int          tl    = fs ? 4 : 16;
    logic [10:0] ex    = exp_frame(1'b0, nn, xb, d);
    int          nb    = exp_bits(1'b0, nn);
    int          ticks = 0;
    int          mism  = 0;
    int          guard = 0;
    bit          wrote = 1'b0;
    bit          started;
    logic [10:0] cap   = '1;
    baud_tick = 1'b0;
    while (ctl_rdata[1] && guard < 10) begin @(negedge clk); guard++; end
    started = !ctl_rdata[1];
    while (!ctl_rdata[1] && guard < 20000) begin
      int idx = ticks / tl;
      if (idx < nb) begin
        cap[idx] = txd_o;
        if (txd_o !== ex[idx]) mism++;
      end
      if (mid && !wrote && ticks >= tl) begin
        hold_wr = 1'b1; hold_wdata = mid_d; wrote = 1'b1;
      end else hold_wr = 1'b0;
      baud_tick = (($urandom % 100) < dens);
      if (baud_tick) ticks++;
      @(negedge clk); guard++;
    end
    baud_tick = 1'b0; hold_wr = 1'b0;
    check(started && mism == 0 && ticks == nb * tl && txd_o == 1'b1,
          {tag, " async frame"}, {21'd0, cap}, {21'd0, ex});
  endtask

  // capture one master-mode frame at rising shift clock edges
  task automatic run_master(input logic [7:0] d, input logic nn, input logic xb,
                            input int dens, input string tag);
    logic [10:0] ex    = exp_frame(1'b1, nn, xb, d);
    int          nb    = exp_bits(1'b1, nn);
    logic [10:0] mask  = 11'((1 << nb) - 1);
    logic [10:0] cap   = '0;
    int          n     = 0;
    int          ticks = 0;
    int          guard = 0;
    logic        prev  = 1'b0;
    baud_tick = 1'b0;
    while (ctl_rdata[1] && guard < 10) begin @(negedge clk); guard++; end
    while (!ctl_rdata[1] && guard < 20000) begin
      if (sclk_o && !prev && n < 11) begin cap[n] = txd_o; n++; end
      prev = sclk_o;
      baud_tick = (($urandom % 100) < dens);
      if (baud_tick) ticks++;
      @(negedge clk); guard++;
    end
    baud_tick = 1'b0;
    check(n == nb && ((cap ^ ex) & mask) == 11'd0, {tag, " master bits"},
          {21'd0, cap & mask}, {21'd0, ex & mask});
    check(ticks == 2 * nb && sclk_o == 1'b0, {tag, " R5 two ticks per bit, clock low"},
          ticks, 2 * nb);
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = '0; hold_wr = 1'b0; hold_wdata = '0;
    baud_tick = 1'b0; port_en = 1'b0; rx_once_en = 1'b0; rx_cont_en = 1'b0; ext_sclk = 1'b0;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(ctl_rdata == 8'h02, "R1 control reset value", ctl_rdata, 8'h02);
    check(txd_o == 1'b1 && sclk_o == 1'b0, "R1 idle pins", {txd_o, sclk_o}, 2'b10);

    // R2 layout and read-only bits
    set_ctl(8'hFF);
    check(ctl_rdata == 8'hFB, "R2 readback all set", ctl_rdata, 8'hFB);
    set_ctl(8'h06);
    check(ctl_rdata == 8'h02, "R2 reserved and status not writable", ctl_rdata, 8'h02);

    // R11 pins off while the port is disabled
    set_ctl(mk_ctl(0, 0, 0, 1, 1, 0));
    put_hold(8'hA5);
    @(negedge clk);
    check(txd_oe == 1'b0 && sclk_oe == 1'b0, "R11 outputs disabled", {txd_oe, sclk_oe}, 2'b00);
    run_async(8'hA5, 0, 0, 1, 100, 0, 8'h00, "R11");
    port_en = 1'b1;
    @(negedge clk);
    check(txd_oe == 1'b1, "R11 data output enabled", txd_oe, 1'b1);

    // R3 load timing
    put_hold(8'h3C);
    check(ctl_rdata[1] == 1'b1, "R3 empty on write edge", ctl_rdata[1], 1'b1);
    @(negedge clk);
    check(ctl_rdata[1] == 1'b0, "R3 full one edge later", ctl_rdata[1], 1'b0);
    run_async(8'h3C, 0, 0, 1, 60, 0, 8'h00, "R3 R4");

    // R4 R8 random asynchronous frames, R9 receive enables ignored here
    for (int k = 0; k < 6; k++) begin
      logic [7:0] d  = 8'($urandom);
      logic       nn = 1'($urandom);
      logic       xb = 1'($urandom);
      logic       fs = 1'($urandom);
      rx_cont_en = 1'($urandom);
      set_ctl(mk_ctl(0, 0, nn, 1, fs, xb));
      put_hold(d);
      run_async(d, nn, xb, fs, 30 + int'($urandom % 71), 0, 8'h00, "R4 R8 R9");
    end
    rx_cont_en = 1'b0;

    // R12 back-to-back via holding register
    set_ctl(mk_ctl(0, 0, 1, 1, 0, 1));
    put_hold(8'h96);
    run_async(8'h96, 1, 1, 0, 80, 1, 8'h4E, "R12 first");
    run_async(8'h4E, 1, 1, 0, 80, 0, 8'h00, "R12 second");

    // R5 R6 R8 master frames
    for (int k = 0; k < 4; k++) begin
      logic [7:0] d  = 8'($urandom);
      logic       nn = 1'($urandom);
      logic       xb = 1'($urandom);
      set_ctl(mk_ctl(1, 1, nn, 1, 1'($urandom), xb));
      put_hold(d);
      run_master(d, nn, xb, 30 + int'($urandom % 71), "R6 R8");
    end

    // R9 blocking in synchronous mode
    set_ctl(mk_ctl(1, 1, 0, 1, 0, 0));
    rx_cont_en = 1'b1;
    put_hold(8'hC3);
    baud_tick = 1'b1;
    repeat (20) @(negedge clk);
    baud_tick = 1'b0;
    check(ctl_rdata[1] == 1'b1 && txd_oe == 1'b0 && sclk_o == 1'b0, "R9 blocked while receiving",
          {ctl_rdata[1], txd_oe, sclk_o}, 3'b100);
    rx_cont_en = 1'b0;
    run_master(8'hC3, 0, 0, 100, "R9 release");

    // R9 abort mid-frame
    put_hold(8'h5A);
    @(negedge clk);
    baud_tick = 1'b1;
    repeat (5) @(negedge clk);
    baud_tick = 1'b0;
    rx_once_en = 1'b1;
    @(negedge clk);
    check(ctl_rdata[1] == 1'b1 && sclk_o == 1'b0, "R9 abort", {ctl_rdata[1], sclk_o}, 2'b10);
    rx_once_en = 1'b0;

    // R10 transmit enable low keeps the byte pending
    set_ctl(mk_ctl(0, 0, 0, 0, 1, 0));
    put_hold(8'h81);
    baud_tick = 1'b1;
    repeat (10) @(negedge clk);
    baud_tick = 1'b0;
    check(ctl_rdata[1] == 1'b1 && txd_o == 1'b1, "R10 nothing sent while disabled",
          {ctl_rdata[1], txd_o}, 2'b11);
    set_ctl(mk_ctl(0, 0, 0, 1, 1, 0));
    run_async(8'h81, 0, 0, 1, 100, 0, 8'h00, "R10 kept byte");

    // R7 R8 slave frames
    for (int k = 0; k < 2; k++) begin
      logic [7:0]  d  = (k == 0) ? 8'hB2 : 8'h47;
      logic        nn = (k == 0);
      logic        xb = 1'b1;
      logic [10:0] ex = exp_frame(1'b1, nn, xb, d);
      int          nb = exp_bits(1'b1, nn);
      logic [10:0] mask = 11'((1 << nb) - 1);
      logic [10:0] cap = '0;
      set_ctl(mk_ctl(1, 0, nn, 1, 0, xb));
      ext_sclk = 1'b0;
      put_hold(d);
      @(negedge clk);
      check(ctl_rdata[1] == 1'b0 && sclk_oe == 1'b0, "R7 loaded, clock not driven",
            {ctl_rdata[1], sclk_oe}, 2'b00);
      for (int b = 0; b < nb; b++) begin
        ext_sclk = 1'b1;
        repeat (4) @(negedge clk);
        cap[b] = txd_o;
        ext_sclk = 1'b0;
        repeat (4) @(negedge clk);
      end
      check(((cap ^ ex) & mask) == 11'd0 && ctl_rdata[1] == 1'b1, "R7 R8 slave bits",
            {21'd0, cap & mask}, {21'd0, ex & mask});
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule